// File: doc/BRIEF.md
# Serial-Triggered DAC FIFO Stepper

This block keeps a small store of DAC codes and walks a DAC output register through them one entry at a time. Software loads the store through a plain parallel write port. Each step copies the entry under the read pointer into the DAC register and moves the pointer on by one. After the last entry the pointer returns to entry zero.

A step has two possible triggers. The first is a serial write frame on SCLK, chip select and data-in that carries a dedicated sequence address. That frame has no contents to write or read back, and its data byte is ignored. The second is a rising edge on an external load pin. The pin only acts while its enable input marks it as a DAC load input. All serial and pin inputs are asynchronous to `clk`. Each passes through a two-flop synchronizer before it is used.

Top module: `dac_fifo_stepper`

## Requirements
- R1: While `rst` is high on a rising `clk` edge, `rd_ptr` and `dac_word` go to zero. The reset is synchronous and active high.
- R2: A frame begins when `cs_n` is low. The first 8 rising SCLK edges shift the address in most-significant bit first. The sequence address is a parameter with default 0xA6, so the bit-reversed value 0x65 does not match.
- R3: A frame whose address matches steps once, on its 16th rising SCLK edge. That step loads `dac_word` with the entry at `rd_ptr` and adds one to `rd_ptr`. The 8 data bits have no effect. The outputs change on the third `clk` rising edge after the SCLK rise is first presented.
- R4: A step taken from entry DEPTH-1 (default 15) loads that entry and returns `rd_ptr` to 0.
- R5: A complete frame with any address other than the sequence address leaves `rd_ptr` and `dac_word` unchanged.
- R6: If `cs_n` rises before the 16th rising SCLK edge, the frame is abandoned and no step occurs. The next frame starts counting from its first edge.
- R7: Rising SCLK edges after the 16th in the same frame cause no further step.
- R8: With `ld_enable` high, each rising edge of `ld_strobe` causes exactly one step, however long the pulse is held.
- R9: With `ld_enable` low, `ld_strobe` has no effect.
- R10: A pulse on `fill_en` writes `fill_data` into entry `fill_idx`. Later steps that reach that entry output the new value.
- R11: A serial step and a pin step that fall on the same `clk` cycle together produce a single step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, asynchronous |
| cs_n | input | 1 | Serial chip select, active low |
| sdin | input | 1 | Serial data in, MSB first |
| ld_strobe | input | 1 | External DAC load pin |
| ld_enable | input | 1 | Marks the pin as a load input |
| fill_en | input | 1 | Store write strobe |
| fill_idx | input | PTR_W (4) | Store entry to write |
| fill_data | input | WIDTH (12) | Word to store |
| dac_word | output | WIDTH (12) | DAC output register |
| rd_ptr | output | PTR_W (4) | Entry the next step will load |

## Verification
The assertions assume that each SCLK level and each `ld_strobe` level is held for at least two `clk` cycles, so the synchronizer sees every edge. They also assume that `ld_enable` is quasi-static. The stimulus holds each SCLK phase for three cycles and each strobe level for at least three. It changes `ld_enable` only while the strobe is low. The data bit is set up during the low phase of SCLK. The simultaneous-trigger case drives the pin edge and the 16th SCLK edge on the same falling `clk` edge, so both reach the step logic on the same cycle.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'b00,
        SRC_SERIAL = 2'b01,
        SRC_PIN    = 2'b10,
        SRC_BOTH   = 2'b11
    } step_src_e;

    function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned depth);
        return (cur + 1 >= depth) ? 0 : cur + 1;
    endfunction

    function automatic step_src_e merge_src(input logic ser, input logic pin);
        return step_src_e'({pin, ser});
    endfunction

endpackage

// File: rtl/dacseq_sync.sv
module dacseq_sync #(
    parameter int          W         = 1,
    parameter logic [W-1:0] RST_VAL  = '0,
    parameter logic [W-1:0] EDGE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] st1, st2, st3;

    always_ff @(posedge clk) begin
        if (rst) begin
            st1 <= RST_VAL;
            st2 <= RST_VAL;
            st3 <= RST_VAL;
        end else begin
            st1 <= async_in;
            st2 <= st1;
            st3 <= st2;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (EDGE_MASK[i]) begin : g_rise
            assign sync_out[i] = st2[i] & ~st3[i];
        end else begin : g_level
            assign sync_out[i] = st2[i];
        end
    end
endmodule

// File: rtl/dacseq_frame.sv
module dacseq_frame #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_BITS = 8,
    parameter logic [ADDR_W-1:0] SEQ_ADDR  = 8'hA6,
    localparam int               FRAME     = ADDR_W + DATA_BITS,
    localparam int               CNT_W     = $clog2(FRAME + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n_s,
    input  logic             sclk_rise,
    input  logic             din_s,
    output logic             seq_hit,
    output logic [CNT_W-1:0] bit_cnt
);
    logic [ADDR_W-1:0] addr_sr;

    always_ff @(posedge clk) begin
        if (rst || cs_n_s) begin
            bit_cnt <= '0;
            addr_sr <= '0;
        end else if (sclk_rise) begin
            if (bit_cnt < CNT_W'(ADDR_W))
                addr_sr <= {addr_sr[ADDR_W-2:0], din_s};
            if (bit_cnt < CNT_W'(FRAME))
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign seq_hit = !cs_n_s && sclk_rise &&
                     (bit_cnt == CNT_W'(FRAME - 1)) && (addr_sr == SEQ_ADDR);
endmodule

// File: rtl/dacseq_store.sv
module dacseq_store #(
    parameter int  DEPTH = 16,
    parameter int  WIDTH = 12,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             step,
    output logic [PTR_W-1:0] ptr,
    output logic [WIDTH-1:0] dac
);
    import dacseq_pkg::*;

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_idx) < DEPTH))
            mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            dac <= '0;
        end else if (step) begin
            dac <= mem[ptr];
            ptr <= PTR_W'(wrap_next(32'(ptr), DEPTH));
        end
    end
endmodule

// File: rtl/dac_fifo_stepper.sv
module dac_fifo_stepper #(
    parameter int                DEPTH     = 16,
    parameter int                WIDTH     = 12,
    parameter int                ADDR_W    = 8,
    parameter int                DATA_BITS = 8,
    parameter logic [ADDR_W-1:0] SEQ_ADDR  = 8'hA6,
    localparam int               PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int               CNT_W     = $clog2(ADDR_W + DATA_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             sdin,
    input  logic             ld_strobe,
    input  logic             ld_enable,
    input  logic             fill_en,
    input  logic [PTR_W-1:0] fill_idx,
    input  logic [WIDTH-1:0] fill_data,
    output logic [WIDTH-1:0] dac_word,
    output logic [PTR_W-1:0] rd_ptr
);
    import dacseq_pkg::*;

    // bit order: {strobe, data, chip select, serial clock}
    logic [3:0]       synced;
    logic             sclk_rise, cs_n_s, din_s, pin_rise;
    logic             seq_hit, pin_step, step;
    logic [CNT_W-1:0] bit_cnt;
    step_src_e        step_src;

    dacseq_sync #(
        .W        (4),
        .RST_VAL  (4'b0010),
        .EDGE_MASK(4'b1001)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_in({ld_strobe, sdin, cs_n, sclk}),
        .sync_out(synced)
    );

    assign sclk_rise = synced[0];
    assign cs_n_s    = synced[1];
    assign din_s     = synced[2];
    assign pin_rise  = synced[3];

    dacseq_frame #(
        .ADDR_W   (ADDR_W),
        .DATA_BITS(DATA_BITS),
        .SEQ_ADDR (SEQ_ADDR)
    ) u_frame (
        .clk      (clk),
        .rst      (rst),
        .cs_n_s   (cs_n_s),
        .sclk_rise(sclk_rise),
        .din_s    (din_s),
        .seq_hit  (seq_hit),
        .bit_cnt  (bit_cnt)
    );

    assign pin_step = pin_rise & ld_enable;
    assign step_src = merge_src(seq_hit, pin_step);
    assign step     = (step_src != SRC_NONE);

    dacseq_store #(
        .DEPTH(DEPTH),
        .WIDTH(WIDTH)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (fill_en),
        .wr_idx (fill_idx),
        .wr_data(fill_data),
        .step   (step),
        .ptr    (rd_ptr),
        .dac    (dac_word)
    );
endmodule

// File: rtl/dac_fifo_stepper_chk.sv
module dac_fifo_stepper_chk #(
    parameter int  DEPTH = 16,
    parameter int  WIDTH = 12,
    parameter int  FRAME = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(FRAME + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             step,
    input logic             pin_step,
    input logic             cs_n_s,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [WIDTH-1:0] dac_word
);
    import dacseq_pkg::*;

    // R3
    ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> rd_ptr == PTR_W'(wrap_next(32'($past(rd_ptr)), DEPTH)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(rd_ptr) && $stable(dac_word)));

    // R6
    abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> bit_cnt == '0);

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(FRAME));

    // R8
    pin_single_chk: assert property (@(posedge clk) disable iff (rst)
        pin_step |=> !pin_step);
endmodule

bind dac_fifo_stepper dac_fifo_stepper_chk #(
    .DEPTH(DEPTH),
    .WIDTH(WIDTH),
    .FRAME(ADDR_W + DATA_BITS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .pin_step(pin_step),
    .cs_n_s  (cs_n_s),
    .bit_cnt (bit_cnt),
    .rd_ptr  (rd_ptr),
    .dac_word(dac_word)
);

// File: tb/dac_fifo_stepper_test.sv
module dac_fifo_stepper_test;
    localparam int DEPTH = 16;
    localparam int WIDTH = 12;

    logic clk = 0, rst = 1;
    logic sclk = 0, cs_n = 1, sdin = 0, ld_strobe = 0, ld_enable = 0;
    logic fill_en = 0;
    logic [3:0] fill_idx = 0;
    logic [11:0] fill_data = 0;
    logic [11:0] dac_word;
    logic [3:0] rd_ptr;

    int vectors = 0, fails = 0;
    string phase = "R1";
    bit done = 0;

    dac_fifo_stepper uut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdin(sdin),
        .ld_strobe(ld_strobe), .ld_enable(ld_enable), .fill_en(fill_en),
        .fill_idx(fill_idx), .fill_data(fill_data),
        .dac_word(dac_word), .rd_ptr(rd_ptr)
    );

    always #4 clk = ~clk;

    // reference model state
    int m_ptr = 0, m_cnt = 0;
    logic [11:0] m_dac = 0;
    logic [7:0] m_addr = 0;
    logic [11:0] m_mem [DEPTH];
    logic [3:0] hq [3];   // input history, {strobe, din, cs_n, sclk}
    bit m_valid = 0;

    always @(posedge clk) begin
        logic ser, pin;
        if (rst) begin
            m_ptr = 0; m_dac = 0; m_cnt = 0; m_addr = 0;
            for (int k = 0; k < 3; k++) hq[k] = 4'b0010;
            m_valid = 1;
        end else begin
            ser = 0;
            if (hq[1][1]) begin
                m_cnt = 0; m_addr = 0;
            end else if (hq[1][0] && !hq[2][0]) begin
                if (m_cnt == 15 && m_addr == 8'hA6) ser = 1;
                if (m_cnt < 8) m_addr = {m_addr[6:0], hq[1][2]};
                if (m_cnt < 16) m_cnt++;
            end
            pin = hq[1][3] && !hq[2][3] && ld_enable;
            if (ser || pin) begin
                m_dac = m_mem[m_ptr];
                m_ptr = (m_ptr + 1) % DEPTH;
            end
            if (fill_en) m_mem[fill_idx] = fill_data;
            hq[2] = hq[1]; hq[1] = hq[0];
            hq[0] = {ld_strobe, sdin, cs_n, sclk};
        end
    end

    always @(posedge clk) begin
        #1;
        if (m_valid && !done) begin
            vectors++;
            if (dac_word !== m_dac || rd_ptr !== m_ptr[3:0]) begin
                fails++;
                $display("FAIL %s model: dac=%h ptr=%0d expected dac=%h ptr=%0d",
                         phase, dac_word, rd_ptr, m_dac, m_ptr);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] pat(input int i);
        return 12'((i * 419 + 53) % 4096);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fill(input int idx, input logic [11:0] val);
        @(negedge clk);
        fill_en = 1; fill_idx = 4'(idx); fill_data = val;
        @(negedge clk);
        fill_en = 0;
    endtask

    task automatic frame(input logic [7:0] a, input logic [7:0] d,
                         input int edges, input bit with_pin);
        logic [15:0] word;
        word = {a, d};
        @(negedge clk); cs_n = 0;
        idle(3);
        for (int i = 0; i < edges; i++) begin
            sclk = 0; sdin = (i < 16) ? word[15 - i] : 1'b0;
            idle(3);
            sclk = 1;
            if (with_pin && i == 15) ld_strobe = 1;
            idle(3);
        end
        sclk = 0; idle(3);
        ld_strobe = 0;
        cs_n = 1; idle(6);
    endtask

    task automatic strobe(input int width);
        @(negedge clk); ld_strobe = 1;
        idle(width);
        ld_strobe = 0;
        idle(6);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired in %s", phase);
        finish_run();
    end

    initial begin
        idle(4);
        rst = 0;
        idle(2);
        phase = "R1";
        chk("R1 reset ptr", int'(rd_ptr), 0);
        chk("R1 reset dac", int'(dac_word), 0);

        phase = "R10";
        for (int i = 0; i < DEPTH; i++) fill(i, pat(i));
        idle(3);

        phase = "R3";
        frame(8'hA6, 8'h00, 16, 0);
        chk("R3 first step dac", int'(dac_word), int'(pat(0)));
        chk("R3 first step ptr", int'(rd_ptr), 1);
        frame(8'hA6, 8'hFF, 16, 0);
        chk("R3 data ignored dac", int'(dac_word), int'(pat(1)));
        chk("R3 data ignored ptr", int'(rd_ptr), 2);

        phase = "R2";
        frame(8'h65, 8'h00, 16, 0);
        chk("R2 reversed address no step", int'(rd_ptr), 2);

        phase = "R5";
        frame(8'hA7, 8'h3C, 16, 0);
        chk("R5 wrong address ptr", int'(rd_ptr), 2);
        chk("R5 wrong address dac", int'(dac_word), int'(pat(1)));

        phase = "R6";
        frame(8'hA6, 8'h00, 15, 0);
        chk("R6 aborted frame", int'(rd_ptr), 2);
        frame(8'hA6, 8'h00, 16, 0);
        chk("R6 frame after abort", int'(rd_ptr), 3);

        phase = "R7";
        frame(8'hA6, 8'h00, 20, 0);
        chk("R7 long frame one step", int'(rd_ptr), 4);
        chk("R7 long frame dac", int'(dac_word), int'(pat(3)));

        phase = "R8";
        @(negedge clk); ld_enable = 1;
        strobe(12);
        chk("R8 long pulse one step", int'(rd_ptr), 5);
        strobe(3);
        chk("R8 short pulse", int'(rd_ptr), 6);
        chk("R8 short pulse dac", int'(dac_word), int'(pat(5)));

        phase = "R9";
        @(negedge clk); ld_enable = 0;
        strobe(5);
        chk("R9 disabled pin", int'(rd_ptr), 6);

        phase = "R4";
        for (int i = 0; i < 10; i++) frame(8'hA6, 8'(i * 17), 16, 0);
        chk("R4 wrap ptr", int'(rd_ptr), 0);
        chk("R4 last entry dac", int'(dac_word), int'(pat(15)));

        phase = "R10";
        fill(0, 12'hBEE);
        idle(2);
        frame(8'hA6, 8'h00, 16, 0);
        chk("R10 refilled entry", int'(dac_word), 12'hBEE);

        phase = "R11";
        @(negedge clk); ld_enable = 1;
        frame(8'hA6, 8'h00, 16, 1);
        chk("R11 merged step ptr", int'(rd_ptr), 2);
        chk("R11 merged step dac", int'(dac_word), int'(pat(1)));

        idle(5);
        finish_run();
    end
endmodule